// File: doc/BRIEF.md
# Debug status flag register

This block keeps the status flags that an external debugger polls while it drives a halted or running core. It follows three event sources. The first is the pipeline's retire pulse. The second is a completion pulse for injected instructions. The third is a set of transactions on a small register bus that stand for accesses to the data-transfer and instruction-transfer channels. A two-bit mode input selects stall, nonblocking or fast transfer behaviour, and that choice decides which bus transactions retire an injected instruction.

The bus offers two read views of the same flag word. A read of the live view returns the current transmit-full and instruction-complete flags. The same read also copies both flags into shadow registers. A read of the shadow view returns those copies. A debugger can therefore sample the live view once and read back a consistent picture later, even after the flags have moved. A sticky activity bit records that at least one instruction retired since the debugger last cleared it, so an idle or deadlocked core can be detected.

Top module: `dbg_status_reg`

## Requirements
- R1: After reset the sticky activity flag, the instruction-complete flag and both shadow copies are 0, and no response is pending.
- R2: A read of the live address (offset 0) returns one cycle later the transmit-full input at bit 26, the sticky flag at bit 25 and the instruction-complete flag at bit 24, all as they stood in the request cycle. Every other bit, 23:22 included, reads 0.
- R3: A live read copies the transmit-full input and the instruction-complete flag into their shadow registers. A read of the shadow address (offset 1) returns those copies at bits 26 and 24, with the sticky flag at bit 25.
- R4: An accepted read of the transmit-data address (offset 5) clears the transmit-full shadow copy.
- R5: A retire pulse sets the sticky flag. An accepted write to the run-control address (offset 2) with write-data bit 3 set clears it, and a write with bit 3 clear leaves it unchanged. When a retire pulse and a clearing write fall in the same cycle, the flag ends at 1.
- R6: A completion pulse sets the instruction-complete flag, and the flag reads 1 from the next cycle on.
- R7: In stall mode (00) or nonblocking mode (01), an accepted write to the instruction-transfer address (offset 3) clears the instruction-complete flag and its shadow copy. In the other modes that write clears neither.
- R8: In fast mode (10), an accepted write to the receive-data address (offset 4) or an accepted read of the transmit-data address clears the instruction-complete flag and its shadow copy. In the other modes neither access touches them. Mode 11 triggers no mode-dependent clear.
- R9: Writes to the live and shadow addresses change no flag.
- R10: When a completion pulse coincides with a clearing access, the instruction-complete flag ends at 0.
- R11: Ready is high from the first clock edge after reset. Every accepted request, read or write, gives exactly one response-valid pulse one cycle later. Writes, and reads of unmapped or channel addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | Pipeline retired one instruction |
| instr_done_i | input | 1 | Injected instruction finished executing |
| tx_full_i | input | 1 | Live transmit-full flag of the data channel |
| mode_i | input | 2 | Transfer mode: 00 stall, 01 nonblocking, 10 fast, 11 none |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | DATA_W | Read data |

## Verification
The hardest cases to reach are coincidences: a shadow copy taken while its source flag is about to be cleared, a completion pulse in the same cycle as a mode-dependent clear, and a retire pulse landing on a sticky-clear write. The bench reaches them by sweeping every mode, every address, both directions and all eight combinations of retire, completion and transmit-full on the same cycle as the access. After each access it reads both views back, so the full flag state after every combination appears at the ports.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;

  typedef enum logic [1:0] {
    MODE_STALL  = 2'd0,
    MODE_NONBLK = 2'd1,
    MODE_FAST   = 2'd2,
    MODE_NONE   = 2'd3
  } xfer_mode_e;

  // bit positions the debugger decodes
  localparam int unsigned TXL_BIT    = 26;
  localparam int unsigned STICKY_BIT = 25;
  localparam int unsigned ICL_BIT    = 24;

  typedef struct packed {
    logic live_rd;
    logic snap_rd;
    logic run_wr;
    logic itr_wr;
    logic rx_wr;
    logic tx_rd;
  } bus_evt_t;

  typedef struct packed {
    logic sticky;
    logic instr;
    logic instr_lat;
    logic tx_lat;
  } flags_t;

endpackage

// File: rtl/dbg_bus_decode.sv
module dbg_bus_decode
  import dbg_stat_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_LIVE   = 0,
  parameter int unsigned ADDR_SNAP   = 1,
  parameter int unsigned ADDR_RUN    = 2,
  parameter int unsigned ADDR_ITR    = 3,
  parameter int unsigned ADDR_RX     = 4,
  parameter int unsigned ADDR_TX     = 5,
  parameter int unsigned RUN_CLR_BIT = 3
) (
  input  logic              accept_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output bus_evt_t          evt_o,
  output logic              run_clr_o
);

  logic rd, wr;
  logic unused_wdata;

  assign rd = accept_i & ~write_i;
  assign wr = accept_i &  write_i;

  always_comb begin
    evt_o         = '0;
    evt_o.live_rd = rd && (addr_i == ADDR_W'(ADDR_LIVE));
    evt_o.snap_rd = rd && (addr_i == ADDR_W'(ADDR_SNAP));
    evt_o.tx_rd   = rd && (addr_i == ADDR_W'(ADDR_TX));
    evt_o.run_wr  = wr && (addr_i == ADDR_W'(ADDR_RUN));
    evt_o.itr_wr  = wr && (addr_i == ADDR_W'(ADDR_ITR));
    evt_o.rx_wr   = wr && (addr_i == ADDR_W'(ADDR_RX));
  end

  assign run_clr_o    = evt_o.run_wr & wdata_i[RUN_CLR_BIT];
  assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/dbg_flag_core.sv
module dbg_flag_core
  import dbg_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bus_evt_t   evt_i,
  input  logic       run_clr_i,
  input  logic [1:0] mode_i,
  input  logic       retire_i,
  input  logic       instr_done_i,
  input  logic       tx_full_i,
  output flags_t     flags_o
);

  xfer_mode_e mode;
  logic       instr_clr;
  flags_t     q, d;

  assign mode = xfer_mode_e'(mode_i);

  // mode picks which transfer access retires an injected instruction
  always_comb begin
    unique case (mode)
      MODE_STALL, MODE_NONBLK: instr_clr = evt_i.itr_wr;
      MODE_FAST:               instr_clr = evt_i.rx_wr | evt_i.tx_rd;
      default:                 instr_clr = 1'b0;
    endcase
  end

  always_comb begin
    d = q;
    // retire has priority over the run-control clear
    if (retire_i)       d.sticky = 1'b1;
    else if (run_clr_i) d.sticky = 1'b0;

    // a new injection beats a completion seen in the same cycle
    if (instr_clr)         d.instr = 1'b0;
    else if (instr_done_i) d.instr = 1'b1;

    if (instr_clr)          d.instr_lat = 1'b0;
    else if (evt_i.live_rd) d.instr_lat = q.instr;

    if (evt_i.tx_rd)        d.tx_lat = 1'b0;
    else if (evt_i.live_rd) d.tx_lat = tx_full_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;

endmodule

// File: rtl/dbg_rsp_path.sv
module dbg_rsp_path
  import dbg_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  bus_evt_t          evt_i,
  input  flags_t            flags_i,
  input  logic              tx_full_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (evt_i.live_rd) begin
      rdata_d[TXL_BIT]    = tx_full_i;
      rdata_d[STICKY_BIT] = flags_i.sticky;
      rdata_d[ICL_BIT]    = flags_i.instr;
    end else if (evt_i.snap_rd) begin
      rdata_d[TXL_BIT]    = flags_i.tx_lat;
      rdata_d[STICKY_BIT] = flags_i.sticky;
      rdata_d[ICL_BIT]    = flags_i.instr_lat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= accept_i;
      rsp_rdata_o <= rdata_d;
    end
  end

endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_stat_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_LIVE   = 0,
  parameter int unsigned ADDR_SNAP   = 1,
  parameter int unsigned ADDR_RUN    = 2,
  parameter int unsigned ADDR_ITR    = 3,
  parameter int unsigned ADDR_RX     = 4,
  parameter int unsigned ADDR_TX     = 5,
  parameter int unsigned RUN_CLR_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic              instr_done_i,
  input  logic              tx_full_i,
  input  logic [1:0]        mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  logic     ready_q;
  logic     accept;
  logic     run_clr;
  bus_evt_t evt;
  flags_t   flags;

  // observation nets for the bound checker
  logic sticky, instr, instr_lat, tx_lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign req_ready_o = ready_q;
  assign accept      = req_valid_i & ready_q;

  dbg_bus_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ADDR_LIVE  (ADDR_LIVE),
    .ADDR_SNAP  (ADDR_SNAP),
    .ADDR_RUN   (ADDR_RUN),
    .ADDR_ITR   (ADDR_ITR),
    .ADDR_RX    (ADDR_RX),
    .ADDR_TX    (ADDR_TX),
    .RUN_CLR_BIT(RUN_CLR_BIT)
  ) i_decode (
    .accept_i (accept),
    .write_i  (req_write_i),
    .addr_i   (req_addr_i),
    .wdata_i  (req_wdata_i),
    .evt_o    (evt),
    .run_clr_o(run_clr)
  );

  dbg_flag_core i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .run_clr_i   (run_clr),
    .mode_i      (mode_i),
    .retire_i    (retire_i),
    .instr_done_i(instr_done_i),
    .tx_full_i   (tx_full_i),
    .flags_o     (flags)
  );

  dbg_rsp_path #(
    .DATA_W(DATA_W)
  ) i_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .evt_i      (evt),
    .flags_i    (flags),
    .tx_full_i  (tx_full_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  assign sticky    = flags.sticky;
  assign instr     = flags.instr;
  assign instr_lat = flags.instr_lat;
  assign tx_lat    = flags.tx_lat;

endmodule

// File: rtl/dbg_status_chk.sv
module dbg_status_chk #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_LIVE   = 0,
  parameter int unsigned ADDR_SNAP   = 1,
  parameter int unsigned ADDR_RUN    = 2,
  parameter int unsigned ADDR_ITR    = 3,
  parameter int unsigned ADDR_RX     = 4,
  parameter int unsigned ADDR_TX     = 5,
  parameter int unsigned RUN_CLR_BIT = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_i,
  input logic              instr_done_i,
  input logic              tx_full_i,
  input logic [1:0]        mode_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              sticky_i,
  input logic              instr_i,
  input logic              instr_lat_i,
  input logic              tx_lat_i
);

  logic acc, rd, wr, live_rd, tx_rd, run_clr, itr_clr, fast_clr;

  assign acc      = req_valid_i & req_ready_o;
  assign rd       = acc & ~req_write_i;
  assign wr       = acc &  req_write_i;
  assign live_rd  = rd && req_addr_i == ADDR_W'(ADDR_LIVE);
  assign tx_rd    = rd && req_addr_i == ADDR_W'(ADDR_TX);
  assign run_clr  = wr && req_addr_i == ADDR_W'(ADDR_RUN) && req_wdata_i[RUN_CLR_BIT];
  assign itr_clr  = wr && req_addr_i == ADDR_W'(ADDR_ITR) && !mode_i[1];
  assign fast_clr = mode_i == 2'b10 &&
                    (tx_rd || (wr && req_addr_i == ADDR_W'(ADDR_RX)));

  p_rsp_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  p_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  p_live_view_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_rd |=> rsp_rdata_o[26] == $past(tx_full_i) && rsp_rdata_o[24] == $past(instr_i)
                && rsp_rdata_o[25] == $past(sticky_i));
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_rdata_o[23:22] == 2'b00);
  p_snap_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_rd |=> tx_lat_i == $past(tx_full_i) && instr_lat_i == $past(instr_i));
  p_txlat_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rd |=> !tx_lat_i);
  p_sticky_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> sticky_i);
  p_sticky_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i && !run_clr |=> $stable(sticky_i));
  p_instr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_done_i && !itr_clr && !fast_clr |=> instr_i);
  p_itr_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    itr_clr |=> !instr_i && !instr_lat_i);
  p_fast_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_clr |=> !instr_i && !instr_lat_i);

endmodule

bind dbg_status_reg dbg_status_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .ADDR_LIVE  (ADDR_LIVE),
  .ADDR_SNAP  (ADDR_SNAP),
  .ADDR_RUN   (ADDR_RUN),
  .ADDR_ITR   (ADDR_ITR),
  .ADDR_RX    (ADDR_RX),
  .ADDR_TX    (ADDR_TX),
  .RUN_CLR_BIT(RUN_CLR_BIT)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .retire_i    (retire_i),
  .instr_done_i(instr_done_i),
  .tx_full_i   (tx_full_i),
  .mode_i      (mode_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .sticky_i    (sticky),
  .instr_i     (instr),
  .instr_lat_i (instr_lat),
  .tx_lat_i    (tx_lat)
);

// File: tb/test_dbg_status_reg.sv
module test_dbg_status_reg;

  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          retire = 1'b0, done = 1'b0, txf = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          valid = 1'b0, write = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid;
  logic [DW-1:0] rdata;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model of the flags
  logic m_sticky = 1'b0, m_instr = 1'b0, m_ilat = 1'b0, m_tlat = 1'b0;

  always #5 clk = ~clk;

  dbg_status_reg i_dbg_status_reg (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .retire_i    (retire),
    .instr_done_i(done),
    .tx_full_i   (txf),
    .mode_i      (mode),
    .req_valid_i (valid),
    .req_ready_o (ready),
    .req_write_i (write),
    .req_addr_i  (addr),
    .req_wdata_i (wdata),
    .rsp_valid_o (rvalid),
    .rsp_rdata_o (rdata)
  );

  function automatic string tag_of(input int a, input bit w);
    case (a)
      0:       return w ? "R9" : "R2";
      1:       return w ? "R9" : "R3";
      2:       return "R5";
      3:       return "R7";
      4:       return "R8";
      5:       return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; the response is checked at the following falling edge
  task automatic step(input bit v, input bit w, input int a, input logic [DW-1:0] wd,
                      input bit ret, input bit dn, input bit tf, input string req);
    logic [DW-1:0] exp_d;
    bit rd, wr, clr;
    @(negedge clk);
    valid = v; write = w; addr = AW'(a); wdata = wd;
    retire = ret; done = dn; txf = tf;
    rd = v && !w;
    wr = v && w;
    exp_d = '0;
    if (rd && a == 0) begin
      exp_d[26] = tf; exp_d[25] = m_sticky; exp_d[24] = m_instr;
    end else if (rd && a == 1) begin
      exp_d[26] = m_tlat; exp_d[25] = m_sticky; exp_d[24] = m_ilat;
    end
    clr = (wr && a == 3 && (mode == 2'd0 || mode == 2'd1)) ||
          (mode == 2'd2 && ((wr && a == 4) || (rd && a == 5)));
    if (rd && a == 5)      m_tlat = 1'b0;
    else if (rd && a == 0) m_tlat = tf;
    if (clr)               m_ilat = 1'b0;
    else if (rd && a == 0) m_ilat = m_instr;
    if (clr)     m_instr = 1'b0;
    else if (dn) m_instr = 1'b1;
    if (ret)                              m_sticky = 1'b1;
    else if (wr && a == 2 && wd[3])       m_sticky = 1'b0;
    @(negedge clk);
    valid = 1'b0; retire = 1'b0; done = 1'b0;
    check({req, "/R11"}, {1'b0, 31'b0, rvalid}, {1'b0, 31'b0, v});
    if (v) check(req, {1'b0, rdata}, {1'b0, exp_d});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R11", {32'b0, ready}, {32'b0, 1'b1});
    check("R1", {32'b0, rvalid}, '0);
    step(1, 0, 0, '0, 0, 0, 0, "R1");
    step(1, 0, 1, '0, 0, 0, 0, "R1");

    // completion visible on the very next cycle
    mode = 2'd0;
    step(0, 0, 0, '0, 0, 1, 0, "R6");
    step(1, 0, 0, '0, 0, 0, 0, "R6");
    // clear beats a coincident completion
    step(1, 1, 3, '0, 0, 1, 0, "R10");
    step(1, 0, 0, '0, 0, 0, 0, "R10");
    // retire beats a coincident sticky clear
    step(1, 1, 2, 32'h8, 1, 0, 0, "R5");
    step(1, 0, 0, '0, 0, 0, 1, "R5");

    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int a = 0; a < 8; a++) begin
        for (int w = 0; w < 2; w++) begin
          for (int c = 0; c < 8; c++) begin
            // prime: set instr, take a shadow with a known tx state
            step(0, 0, 0, '0, 0, 1, 0, tag_of(a, w[0]));
            step(1, 0, 0, '0, c[1], 0, c[2] ^ c[0], tag_of(a, w[0]));
            step(1, w[0], a, c[0] ? 32'hFFFF_FFFF : 32'h0000_0004,
                 c[0], c[1], c[2], tag_of(a, w[0]));
            step(1, 0, 1, '0, 0, 0, 0, tag_of(a, w[0]));
            step(1, 0, 0, '0, 0, 0, c[0], tag_of(a, w[0]));
          end
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule